// File: doc/BRIEF.md
# Serial Controller Host Register and Interrupt Unit

This block is the processor-facing side of a single-channel asynchronous serial controller. A host reaches four byte-wide registers through a 2-bit address with separate read and write strobes. The registers are the data port, a read-only status word, a command register and a line-control register. The receiver and transmitter shift engines sit outside this block. The block holds the byte they exchange, collects their error and handshake flags, and hands the line-format settings to them unchanged.

The command register sets the terminal-ready output, the receive interrupt enable and a 2-bit transmitter mode. The mode selects request-to-send, transmitter enable, transmit interrupt and continuous break. The carrier-detect and data-set-ready inputs are synchronised, reported as levels, and watched for changes. A single pending-interrupt flag drives an active-low request line. Reading the status word clears that flag. When terminal-ready is off, the whole controller goes quiet: no bytes are accepted, the transmitter is held, and no interrupt source can raise the flag.

Top module: `ser_host_regs`

## Requirements
- R1: After reset the command and control registers read 0x00, status reads 0x10 (only bit 4, transmit empty, set, with modem inputs low), irq_n_o, dtr_n_o and rts_n_o are high, and tx_req_o and tx_break_o are low.
- R2: A write to address 3 (control) or address 2 (command) is read back unchanged at the same address and appears on ctrl_o / cmd_o.
- R3: A byte accepted from the receiver is returned by a read of address 0 and sets status bit 3. A read of address 0 clears bit 3 from the next cycle.
- R4: Status bit 0 (parity error) and bit 1 (framing error) take the flags that came with each accepted byte and keep them until the next accepted byte.
- R5: A received byte that arrives while bit 3 is set and no data read takes place in that cycle sets status bit 2 (overrun) and is discarded, so the held byte is kept. A read of address 0 clears bit 2.
- R6: A write to address 0 puts the byte on tx_data_o and clears status bit 4. A tx_take_i pulse sets bit 4 again while the transmitter is running.
- R7: Command bits 3:2 select the transmitter mode. Mode 00 drives rts_n_o high; modes 01, 10 and 11 drive it low. tx_req_o can be high only in modes 01 and 10, and tx_break_o is high only in mode 11.
- R8: dtr_n_o is low exactly when command bit 0 is set. With bit 0 clear, received bytes and tx_take_i are ignored, tx_req_o and tx_break_o stay low, and no source sets the interrupt flag.
- R9: With command bits 0 and 1 set, an accepted byte sets status bit 7 and drives irq_n_o low.
- R10: In transmitter mode 10 with terminal-ready on, a transmit-empty 0-to-1 change caused by tx_take_i sets bit 7. Mode 01 raises no interrupt.
- R11: Status bits 5 and 6 show the carrier-detect and data-set-ready levels SYNC_STAGES cycles after the inputs change. Any change of either level sets bit 7 whenever terminal-ready is on, whatever command bits 1 to 3 hold.
- R12: A status read returns bit 7 as it stood and clears it from the next cycle, leaving bits 3 and 4 untouched. An interrupt event in the same cycle as the read leaves bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 command, 3 control |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| rx_data_i | input | DATA_W | Byte from the receiver |
| rx_valid_i | input | 1 | One-cycle pulse: rx_data_i holds a new byte |
| rx_parity_err_i | input | 1 | Parity error for the byte with rx_valid_i |
| rx_frame_err_i | input | 1 | Framing error for the byte with rx_valid_i |
| rx_en_o | output | 1 | Receiver enable (terminal-ready on) |
| tx_data_o | output | DATA_W | Byte held for the transmitter |
| tx_req_o | output | 1 | A byte is waiting and the transmitter runs |
| tx_take_i | input | 1 | Transmitter has taken the held byte |
| tx_break_o | output | 1 | Transmit continuous break |
| dcd_i | input | 1 | Carrier-detect level, asynchronous |
| dsr_i | input | 1 | Data-set-ready level, asynchronous |
| dtr_n_o | output | 1 | Terminal-ready, active low |
| rts_n_o | output | 1 | Request-to-send, active low |
| irq_n_o | output | 1 | Interrupt request, active low |
| cmd_o | output | 8 | Command register contents for the datapath |
| ctrl_o | output | 8 | Control register contents (rate, clock source, word length, stop bits) |

## Verification
The embedded assertions check the cycle-level rules on every cycle. A status read with no coincident event leaves the flag clear. A coincident event always wins. An overrun keeps the held byte, a data write leaves the holding register full, and a blocked controller never raises the flag. Other behaviours only show in the bench's scenarios, which sweep the control register over all 256 values, cover every transmitter mode with terminal-ready on and off, and cover all four error-flag combinations. These are the full read-back values of the status word, the mode decoding onto the handshake pins, the synchroniser latency on the modem levels, and the ordering of overrun and clear events as seen by the host.

// File: rtl/ser_regs_pkg.sv
package ser_regs_pkg;

   localparam int REG_W = 8;

   localparam logic [1:0] ADR_DATA = 2'd0;
   localparam logic [1:0] ADR_STAT = 2'd1;
   localparam logic [1:0] ADR_CMD  = 2'd2;
   localparam logic [1:0] ADR_CTRL = 2'd3;

   // status bit positions (host software decodes these)
   localparam int ST_PAR  = 0;
   localparam int ST_FRM  = 1;
   localparam int ST_OVR  = 2;
   localparam int ST_RXF  = 3;
   localparam int ST_TXE  = 4;
   localparam int ST_DCD  = 5;
   localparam int ST_DSR  = 6;
   localparam int ST_IRQ  = 7;

   // command bit positions
   localparam int CM_DTR   = 0;
   localparam int CM_RXIE  = 1;
   localparam int CM_MODE0 = 2;
   localparam int CM_MODE1 = 3;

   typedef enum logic [1:0] {
      TXM_OFF     = 2'b00,
      TXM_RUN     = 2'b01,
      TXM_RUN_IRQ = 2'b10,
      TXM_BREAK   = 2'b11
   } tx_mode_e;

   // interrupt source indices
   localparam int SRC_RX  = 0;
   localparam int SRC_TX  = 1;
   localparam int SRC_DCD = 2;
   localparam int SRC_DSR = 3;
   localparam int N_SRC   = 4;

endpackage

// File: rtl/ser_line_sync.sv
module ser_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic changed
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("ser_line_sync: STAGES must be within 0..4");
      end
   endgenerate

   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else if (STAGES == 1) sh_q <= din;
            else sh_q <= {sh_q[(STAGES > 1 ? STAGES-2 : 0):0], din};
         end
         assign level = sh_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else prev_q <= level;
   end

   assign changed = (level != prev_q);

   // R11: a reported change is followed by the new level being remembered
   p_change_settles_r11: assert property (@(posedge clk) disable iff (!rst_n)
      changed |=> (prev_q == $past(level)));

endmodule

// File: rtl/ser_rx_hold.sv
module ser_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              strobe,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              par_in,
   input  logic              frm_in,
   input  logic              take,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q,
   output logic              par_q,
   output logic              frm_q,
   output logic              ovr_q,
   output logic              got_byte
);

   logic arrive;
   logic blocked;

   assign arrive   = strobe && enable;
   assign blocked  = full_q && !take;
   assign got_byte = arrive && !blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         par_q  <= 1'b0;
         frm_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (take) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
         end
         if (arrive) begin
            if (blocked) begin
               ovr_q <= 1'b1;
            end else begin
               data_q <= byte_in;
               full_q <= 1'b1;
               par_q  <= par_in;
               frm_q  <= frm_in;
            end
         end
      end
   end

   // R5: an arrival against an unread byte flags overrun and keeps the byte
   p_overrun_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && enable && full_q && !take) |=> (ovr_q && $stable(data_q)));

   // R3: a data read without a new arrival empties the holding register
   p_take_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !(strobe && enable)) |=> !full_q);

   // R8: nothing arrives while the controller is disabled
   p_disabled_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !take) |=> ($stable(full_q) && $stable(data_q)));

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              run,
   input  logic              take,
   output logic [DATA_W-1:0] data_q,
   output logic              empty_q,
   output logic              drained
);

   assign drained = take && run && !empty_q && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         empty_q <= 1'b1;
      end else if (load) begin
         data_q  <= din;
         empty_q <= 1'b0;
      end else if (drained) begin
         empty_q <= 1'b1;
      end
   end

   // R6: a host write always leaves a byte waiting
   p_load_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !empty_q);

   // R8: a stopped transmitter cannot drain the holding register
   p_stopped_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(empty_q));

endmodule

// File: rtl/ser_irq_ctl.sv
module ser_irq_ctl #(
   parameter int N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_evt,
   input  logic [N_SRC-1:0] src_en,
   input  logic             clear,
   output logic             flag_q
);

   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("ser_irq_ctl: N_SRC must be at least 1");
      end
   endgenerate

   logic any_evt;
   assign any_evt = |(src_evt & src_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else if (any_evt) flag_q <= 1'b1;
      else if (clear) flag_q <= 1'b0;
   end

   // R12: a status read with no coincident event clears the flag
   p_read_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !any_evt) |=> !flag_q);

   // R12: an event is never lost to a coincident status read
   p_event_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |=> flag_q);

   // R12: without an event or a read the flag holds
   p_flag_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_evt && !clear) |=> $stable(flag_q));

endmodule

// File: rtl/ser_host_regs.sv
module ser_host_regs
   import ser_regs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_valid_i,
   input  logic              rx_parity_err_i,
   input  logic              rx_frame_err_i,
   output logic              rx_en_o,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_req_o,
   input  logic              tx_take_i,
   output logic              tx_break_o,
   input  logic              dcd_i,
   input  logic              dsr_i,
   output logic              dtr_n_o,
   output logic              rts_n_o,
   output logic              irq_n_o,
   output logic [7:0]        cmd_o,
   output logic [7:0]        ctrl_o
);

   localparam int N_MODEM = 2;

   generate
      if (DATA_W < 5 || DATA_W > REG_W) begin : g_bad_width
         $error("ser_host_regs: DATA_W must be within 5..8");
      end
   endgenerate

   // ---------------- register decode ----------------
   logic rd_data, rd_stat, wr_data, wr_cmd, wr_ctrl;
   assign rd_data = reg_rd && (reg_addr == ADR_DATA);
   assign rd_stat = reg_rd && (reg_addr == ADR_STAT);
   assign wr_data = reg_wr && (reg_addr == ADR_DATA);
   assign wr_cmd  = reg_wr && (reg_addr == ADR_CMD);
   assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);

   logic [REG_W-1:0] cmd_q, ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_cmd)  cmd_q  <= reg_wdata;
         if (wr_ctrl) ctrl_q <= reg_wdata;
      end
   end

   // ---------------- command decode ----------------
   logic     dtr_on;
   logic     rx_irq_on;
   tx_mode_e tx_mode;
   logic     tx_run;

   assign dtr_on    = cmd_q[CM_DTR];
   assign rx_irq_on = cmd_q[CM_RXIE];
   assign tx_mode   = tx_mode_e'(cmd_q[CM_MODE1:CM_MODE0]);
   assign tx_run    = dtr_on && (tx_mode == TXM_RUN || tx_mode == TXM_RUN_IRQ);

   // ---------------- receive side ----------------
   logic [DATA_W-1:0] rx_q;
   logic rx_full, rx_par, rx_frm, rx_ovr, rx_evt;

   ser_rx_hold #(.DATA_W(DATA_W)) u_rx_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (dtr_on),
      .strobe   (rx_valid_i),
      .byte_in  (rx_data_i),
      .par_in   (rx_parity_err_i),
      .frm_in   (rx_frame_err_i),
      .take     (rd_data),
      .data_q   (rx_q),
      .full_q   (rx_full),
      .par_q    (rx_par),
      .frm_q    (rx_frm),
      .ovr_q    (rx_ovr),
      .got_byte (rx_evt)
   );

   // ---------------- transmit side ----------------
   logic tx_empty, tx_evt;

   ser_tx_hold #(.DATA_W(DATA_W)) u_tx_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_data),
      .din     (reg_wdata[DATA_W-1:0]),
      .run     (tx_run),
      .take    (tx_take_i),
      .data_q  (tx_data_o),
      .empty_q (tx_empty),
      .drained (tx_evt)
   );

   // ---------------- modem inputs ----------------
   logic [N_MODEM-1:0] modem_in, modem_lvl, modem_chg;
   assign modem_in = {dsr_i, dcd_i};

   generate
      for (genvar g = 0; g < N_MODEM; g++) begin : g_modem
         ser_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (modem_in[g]),
            .level   (modem_lvl[g]),
            .changed (modem_chg[g])
         );
      end
   endgenerate

   // ---------------- interrupt ----------------
   logic [N_SRC-1:0] src_evt, src_en;
   logic             irq_flag;

   always_comb begin
      src_evt          = '0;
      src_en           = '0;
      src_evt[SRC_RX]  = rx_evt;
      src_evt[SRC_TX]  = tx_evt;
      src_evt[SRC_DCD] = modem_chg[0];
      src_evt[SRC_DSR] = modem_chg[1];
      src_en[SRC_RX]   = dtr_on && rx_irq_on;
      src_en[SRC_TX]   = dtr_on && (tx_mode == TXM_RUN_IRQ);
      src_en[SRC_DCD]  = dtr_on;
      src_en[SRC_DSR]  = dtr_on;
   end

   ser_irq_ctl #(.N_SRC(N_SRC)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_evt (src_evt),
      .src_en  (src_en),
      .clear   (rd_stat),
      .flag_q  (irq_flag)
   );

   // ---------------- status and read mux ----------------
   logic [REG_W-1:0] status;

   always_comb begin
      status         = '0;
      status[ST_PAR] = rx_par;
      status[ST_FRM] = rx_frm;
      status[ST_OVR] = rx_ovr;
      status[ST_RXF] = rx_full;
      status[ST_TXE] = tx_empty;
      status[ST_DCD] = modem_lvl[0];
      status[ST_DSR] = modem_lvl[1];
      status[ST_IRQ] = irq_flag;
   end

   always_comb begin
      unique case (reg_addr)
         ADR_DATA: reg_rdata = REG_W'(rx_q);
         ADR_STAT: reg_rdata = status;
         ADR_CMD:  reg_rdata = cmd_q;
         default:  reg_rdata = ctrl_q;
      endcase
   end

   // ---------------- pins ----------------
   assign rx_en_o    = dtr_on;
   assign dtr_n_o    = !dtr_on;
   assign rts_n_o    = (tx_mode == TXM_OFF);
   assign tx_req_o   = tx_run && !tx_empty;
   assign tx_break_o = dtr_on && (tx_mode == TXM_BREAK);
   assign irq_n_o    = !irq_flag;
   assign cmd_o      = cmd_q;
   assign ctrl_o     = ctrl_q;

   // R8: with terminal-ready off an idle interrupt line stays idle
   p_dtr_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtr_on && irq_n_o && !wr_cmd) |=> irq_n_o);

   // R7: the transmitter never requests data while sending break
   p_break_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_break_o |-> !tx_req_o);

endmodule

// File: tb/ser_host_regs_tb.sv
module ser_host_regs_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic [7:0] rx_data_i = '0;
   logic       rx_valid_i = 1'b0, rx_parity_err_i = 1'b0, rx_frame_err_i = 1'b0;
   logic       rx_en_o;
   logic [7:0] tx_data_o;
   logic       tx_req_o, tx_take_i = 1'b0, tx_break_o;
   logic       dcd_i = 1'b0, dsr_i = 1'b0;
   logic       dtr_n_o, rts_n_o, irq_n_o;
   logic [7:0] cmd_o, ctrl_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ser_host_regs #(.DATA_W(8), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i),
      .rx_parity_err_i(rx_parity_err_i), .rx_frame_err_i(rx_frame_err_i),
      .rx_en_o(rx_en_o), .tx_data_o(tx_data_o), .tx_req_o(tx_req_o),
      .tx_take_i(tx_take_i), .tx_break_o(tx_break_o), .dcd_i(dcd_i),
      .dsr_i(dsr_i), .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o),
      .irq_n_o(irq_n_o), .cmd_o(cmd_o), .ctrl_o(ctrl_o)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rxb(input logic [7:0] b, input logic pe, input logic fe);
      rx_data_i = b; rx_parity_err_i = pe; rx_frame_err_i = fe; rx_valid_i = 1'b1;
      @(negedge clk);
      rx_valid_i = 1'b0; rx_parity_err_i = 1'b0; rx_frame_err_i = 1'b0;
   endtask

   task automatic take_pulse();
      tx_take_i = 1'b1;
      @(negedge clk);
      tx_take_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog (all R) actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(2'd1, v); check("R1 status", v, 8'h10);
      rd(2'd2, v); check("R1 command", v, 8'h00);
      rd(2'd3, v); check("R1 control", v, 8'h00);
      check("R1 pins irq/dtr/rts", {5'b0, irq_n_o, dtr_n_o, rts_n_o}, 8'h07);
      check("R1 req/break", {6'b0, tx_req_o, tx_break_o}, 8'h00);

      // R2 control register sweep
      for (int i = 0; i < 256; i++) begin
         wr(2'd3, 8'(i));
         rd(2'd3, v);
         check("R2 control readback", v, 8'(i));
         check("R2 ctrl_o", ctrl_o, 8'(i));
      end
      wr(2'd2, 8'hF0);
      rd(2'd2, v); check("R2 command readback", v, 8'hF0);
      check("R2 cmd_o", cmd_o, 8'hF0);

      // R8 terminal-ready pin, R7 mode sweep with a byte waiting
      wr(2'd2, 8'h01);
      check("R8 dtr_n low", {7'b0, dtr_n_o}, 8'h00);
      wr(2'd0, 8'h5A);
      for (int d = 0; d < 2; d++) begin
         for (int m = 0; m < 4; m++) begin
            wr(2'd2, 8'(d | (m << 2)));
            check("R7 rts_n", {7'b0, rts_n_o}, {7'b0, m == 0});
            check("R7 R8 tx_req", {7'b0, tx_req_o}, {7'b0, d == 1 && (m == 1 || m == 2)});
            check("R7 R8 tx_break", {7'b0, tx_break_o}, {7'b0, d == 1 && m == 3});
            check("R8 irq idle", {7'b0, irq_n_o}, 8'h01);
         end
      end

      // R6 transmit, mode 01 without interrupt
      wr(2'd2, 8'h05);
      wr(2'd0, 8'hA5);
      check("R6 tx_data", tx_data_o, 8'hA5);
      rd(2'd1, v); check("R6 empty cleared", v, 8'h00);
      check("R6 tx_req", {7'b0, tx_req_o}, 8'h01);
      take_pulse();
      rd(2'd1, v); check("R6 empty set", v, 8'h10);
      check("R10 no irq in mode 01", {7'b0, irq_n_o}, 8'h01);

      // R10 transmit interrupt in mode 10
      wr(2'd2, 8'h09);
      wr(2'd0, 8'h3C);
      take_pulse();
      check("R10 irq_n", {7'b0, irq_n_o}, 8'h00);
      rd(2'd1, v); check("R10 R12 status with irq", v, 8'h90);
      check("R12 irq_n released", {7'b0, irq_n_o}, 8'h01);
      rd(2'd1, v); check("R12 status after read", v, 8'h10);

      // R9 receive interrupt, R3 data path
      wr(2'd2, 8'h03);
      rxb(8'h81, 1'b0, 1'b0);
      check("R9 irq_n", {7'b0, irq_n_o}, 8'h00);
      rd(2'd1, v); check("R9 status", v, 8'h98);
      rd(2'd1, v); check("R12 keeps rx full", v, 8'h18);
      rd(2'd0, v); check("R3 data", v, 8'h81);
      rd(2'd1, v); check("R3 full cleared", v, 8'h10);

      // R4 error flag combinations
      wr(2'd2, 8'h01);
      for (int e = 0; e < 4; e++) begin
         rxb(8'(8'h40 + e), e[0], e[1]);
         rd(2'd1, v); check("R4 status with byte", v, 8'(8'h18 | e));
         rd(2'd0, v); check("R4 data", v, 8'(8'h40 + e));
         rd(2'd1, v); check("R4 flags held", v, 8'(8'h10 | e));
      end
      check("R4 no irq without enable", {7'b0, irq_n_o}, 8'h01);

      // R5 overrun
      rxb(8'h11, 1'b0, 1'b0);
      rxb(8'h22, 1'b1, 1'b1);
      rd(2'd1, v); check("R5 overrun status", v, 8'h1C);
      rd(2'd0, v); check("R5 first byte kept", v, 8'h11);
      rd(2'd1, v); check("R5 overrun cleared", v, 8'h10);

      // R8 terminal-ready off blocks receiver, transmitter and interrupts
      wr(2'd2, 8'h02);
      check("R8 dtr_n high", {7'b0, dtr_n_o}, 8'h01);
      check("R8 rx_en off", {7'b0, rx_en_o}, 8'h00);
      rxb(8'h33, 1'b1, 1'b0);
      rd(2'd1, v); check("R8 rx ignored status", v, 8'h10);
      rd(2'd0, v); check("R8 rx ignored data", v, 8'h11);
      check("R8 no irq", {7'b0, irq_n_o}, 8'h01);
      wr(2'd0, 8'h44);
      take_pulse();
      rd(2'd1, v); check("R8 take ignored", v, 8'h00);
      wr(2'd2, 8'h05);
      take_pulse();
      rd(2'd1, v); check("R6 take after enable", v, 8'h10);

      // R11 modem changes
      wr(2'd2, 8'h01);
      dcd_i = 1'b1;
      idle(4);
      check("R11 dcd irq", {7'b0, irq_n_o}, 8'h00);
      rd(2'd1, v); check("R11 dcd status", v, 8'hB0);
      rd(2'd1, v); check("R11 R12 dcd after read", v, 8'h30);
      dsr_i = 1'b1;
      idle(4);
      rd(2'd1, v); check("R11 dsr status", v, 8'hF0);
      rd(2'd1, v); check("R11 dsr after read", v, 8'h70);
      wr(2'd2, 8'h00);
      dcd_i = 1'b0;
      idle(4);
      check("R8 R11 change masked by dtr off", {7'b0, irq_n_o}, 8'h01);
      rd(2'd1, v); check("R11 level follows", v, 8'h50);

      // R12 event in the same cycle as the status read
      wr(2'd2, 8'h03);
      reg_addr = 2'd1; reg_rd = 1'b1;
      rx_data_i = 8'h66; rx_valid_i = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0; rx_valid_i = 1'b0;
      check("R12 read before event", v, 8'h50);
      check("R12 event wins irq_n", {7'b0, irq_n_o}, 8'h00);
      rd(2'd1, v); check("R12 event wins status", v, 8'hD8);
      rd(2'd0, v); check("R3 coincident byte", v, 8'h66);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule